// File: doc/BRIEF.md
# Wait-stated APB Register-File Subordinate

This block answers APB transfers from a manager and fronts a bank of four 32-bit registers that sit behind a slow backing store. Every transfer takes a fixed number of cycles. The ready response comes from a flip-flop, so no decode ripple can reach the manager's sampling point. The block only asserts ready once the store's latency has elapsed.

Each access is checked against a small access policy while it is in flight. An access to an offset outside the bank fails. A write to the read-only word fails. An access to the privileged word without the privilege attribute also fails. A failing access completes normally but raises the error response. An errored write leaves the bank untouched, and an errored read returns zero. Writes honour per-byte lane enables, while reads always return a whole word.

Top module: `apb_regfile_sub`

## Requirements
- R1: With the default latency of 4, a transfer spends one SETUP cycle (select high, enable low) and then 3 ACCESS cycles with `ready_o` low. `ready_o` rises in the next ACCESS cycle.
- R2: `ready_o` is high for exactly one cycle per transfer, and only while `sel_i` and `enable_i` are both high.
- R3: A SETUP cycle that directly follows a completion cycle restarts the latency count. The back-to-back transfer therefore sees the same number of wait cycles as one that follows an idle gap.
- R4: `err_o` is high only in a completion cycle, together with `ready_o`. It is low in every wait, idle and SETUP cycle.
- R5: The word index is `addr_i[7:2]`. An index of 4 or more (offset 0x10 and above) is unmapped, and both reads and writes to it complete with `err_o` high.
- R6: Word 3 (offset 0xC) is read-only and resets to 0xC0DE0001. A write to it completes with `err_o` high and leaves the word unchanged. A read of it succeeds.
- R7: Word 2 (offset 0x8) needs `prot_i[0]`=1. A read or write to it with `prot_i[0]`=0 completes with `err_o` high.
- R8: On a successful write, `strb_i[i]` high copies `wdata_i[8i+7:8i]` into byte i of the addressed word. A byte whose strobe bit is low is left unchanged.
- R9: On a read, `strb_i` is ignored, and the full 32-bit word is returned even when `strb_i`=0.
- R10: An errored write changes no register.
- R11: `rdata_o` is zero in every cycle except the completion cycle of a successful read. It is zero on an errored read.
- R12: While `rst` is high and after its release, `ready_o`, `err_o` and `rdata_o` are low. Words 0 to 2 read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Subordinate select |
| enable_i | input | 1 | Phase marker, high in ACCESS |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address; bits [7:2] pick the word |
| wdata_i | input | 32 | Write data |
| strb_i | input | 4 | Write byte-lane enables |
| prot_i | input | 3 | Protection attributes; bit 0 = privileged |
| rdata_o | output | 32 | Read data, valid in the completion cycle |
| ready_o | output | 1 | Transfer completion |
| err_o | output | 1 | Error response, valid with `ready_o` |

## Verification
The in-RTL assertions watch the handshake shape on every cycle:
- `ready_o` appears only inside an ACCESS phase and lasts a single cycle.
- The latency count has reached its limit whenever `ready_o` is high.
- `err_o` never appears without `ready_o`.
- `rdata_o` is zero off the completion edge.
- The read-only word never moves.

Only the bench's scenarios can show the data-dependent results. These are the exact wait count after an immediate back-to-back SETUP, the decode of unmapped, read-only and privileged words, the merging of partial byte-lane writes, and whether an errored write really left the bank untouched.

// File: rtl/apb_rf_pkg.sv
package apb_rf_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int LATENCY   = 4;
  localparam int RO_IDX    = 3;
  localparam int PRIV_IDX  = 2;
  localparam logic [DATA_W-1:0] RO_INIT = 32'hC0DE_0001;

  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int CNT_W = $clog2(LATENCY + 1);

  typedef enum logic [1:0] {
    ACC_OK       = 2'd0,
    ACC_UNMAPPED = 2'd1,
    ACC_RDONLY   = 2'd2,
    ACC_PRIV     = 2'd3
  } acc_status_e;
endpackage

// File: rtl/rf_wait_timer.sv
module rf_wait_timer #(
  parameter int LAT   = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_i,
  input  logic             enable_i,
  output logic             ready_o,
  output logic             finish_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  initial begin
    if (LAT < 2) $error("rf_wait_timer: LAT must be at least 2");
  end

  // Cycle in which the next edge raises ready.
  assign finish_o = sel_i & enable_i & ~rdy_q & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= finish_o;
      if (sel_i & enable_i & rdy_q) begin
        cnt_q <= '0;
      end else if (sel_i & ~enable_i) begin
        cnt_q <= CNT_W'(1);
      end else if (sel_i & enable_i & (cnt_q < CNT_W'(LAT))) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o = rdy_q;
  assign count_o = cnt_q;

  assert_latency_met_R1: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> (cnt_q == CNT_W'(LAT)));
  assert_ready_in_access_R2: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> (sel_i & enable_i));
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> !rdy_q);
endmodule

// File: rtl/rf_access_check.sv
module rf_access_check
  import apb_rf_pkg::*;
#(
  parameter int AW       = 8,
  parameter int WORDS    = 4,
  parameter int RO_WORD  = 3,
  parameter int PRV_WORD = 2
) (
  input  logic          [AW-1:0] addr_i,
  input  logic                   write_i,
  input  logic          [2:0]    prot_i,
  output acc_status_e            status_o,
  output logic          [AW-3:0] word_o
);
  logic [AW-3:0] w;
  assign w      = addr_i[AW-1:2];
  assign word_o = w;

  // Priority: unmapped, then read-only, then privilege.
  always_comb begin
    if (int'(w) >= WORDS)                          status_o = ACC_UNMAPPED;
    else if (write_i && int'(w) == RO_WORD)        status_o = ACC_RDONLY;
    else if (int'(w) == PRV_WORD && !prot_i[0])    status_o = ACC_PRIV;
    else                                           status_o = ACC_OK;
  end
endmodule

// File: rtl/rf_byte_store.sv
module rf_byte_store #(
  parameter int              DW     = 32,
  parameter int              WORDS  = 4,
  parameter int              IW     = 2,
  parameter int              RO_WORD = 3,
  parameter logic [DW-1:0]   RO_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW/8-1:0]   strb_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int NL = DW / 8;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= (w == RO_WORD) ? RO_VAL : '0;
    end else if (we_i) begin
      for (int b = 0; b < NL; b++) begin
        if (strb_i[b]) mem[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_o = mem[idx_i];

  assert_ro_word_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    mem[RO_WORD] == RO_VAL);
endmodule

// File: rtl/apb_regfile_sub.sv
module apb_regfile_sub
  import apb_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              enable_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  strb_i,
  input  logic [2:0]        prot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              err_o
);
  logic              rdy;
  logic              finish;
  logic [CNT_W-1:0]  cnt;
  acc_status_e       status;
  logic [ADDR_W-3:0] word;
  logic [DATA_W-1:0] store_rd;
  logic              commit;
  logic              bad;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  rf_wait_timer #(.LAT(LATENCY), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .sel_i(sel_i), .enable_i(enable_i),
    .ready_o(rdy), .finish_o(finish), .count_o(cnt)
  );

  rf_access_check #(.AW(ADDR_W), .WORDS(NUM_WORDS), .RO_WORD(RO_IDX),
                    .PRV_WORD(PRIV_IDX)) u_check (
    .addr_i(addr_i), .write_i(write_i), .prot_i(prot_i),
    .status_o(status), .word_o(word)
  );

  assign bad    = (status != ACC_OK);
  assign commit = sel_i & enable_i & rdy & write_i & ~bad;

  rf_byte_store #(.DW(DATA_W), .WORDS(NUM_WORDS), .IW(IDX_W),
                  .RO_WORD(RO_IDX), .RO_VAL(RO_INIT)) u_store (
    .clk(clk), .rst(rst), .we_i(commit), .idx_i(word[IDX_W-1:0]),
    .strb_i(strb_i), .wdata_i(wdata_i), .rdata_o(store_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= finish & bad;
      rdata_q <= (finish & ~bad & ~write_i) ? store_rd : '0;
    end
  end

  assign ready_o = rdy;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  assert_err_needs_ready_R4: assert property (@(posedge clk) disable iff (rst)
    err_q |-> rdy);
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> (rdata_q == '0));
  assert_err_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (rdata_q == '0));
endmodule

// File: tb/apb_regfile_sub_test.sv
`timescale 1ns/1ps
module apb_regfile_sub_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic [2:0]  prot = '0;
  logic [31:0] rdata;
  logic        ready, err;

  int checks = 0;
  int failures = 0;
  localparam int EXP_WAITS = 3;

  always #10 clk = ~clk;

  apb_regfile_sub uut (
    .clk(clk), .rst(rst), .sel_i(sel), .enable_i(en), .write_i(wr),
    .addr_i(addr), .wdata_i(wdata), .strb_i(strb), .prot_i(prot),
    .rdata_o(rdata), .ready_o(ready), .err_o(err)
  );

  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  s;
    logic [2:0]  p;
    logic        e;
    logic [31:0] r;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h1122_3344, 4'hF, 3'd0, 1'b0, 32'h0},          // R8 full write
    '{1'b0, 8'h00, 32'h0,         4'hF, 3'd0, 1'b0, 32'h1122_3344},  // R8
    '{1'b1, 8'h04, 32'hAABB_CCDD, 4'h5, 3'd0, 1'b0, 32'h0},          // R8 lanes 0,2
    '{1'b0, 8'h04, 32'h0,         4'h0, 3'd0, 1'b0, 32'h00BB_00DD},  // R8 R9 strb=0 read
    '{1'b1, 8'h08, 32'h5555_5555, 4'hF, 3'd0, 1'b1, 32'h0},          // R7 R10
    '{1'b0, 8'h08, 32'h0,         4'hF, 3'd0, 1'b1, 32'h0},          // R7 R11
    '{1'b1, 8'h08, 32'h1234_5678, 4'hF, 3'd1, 1'b0, 32'h0},          // R7 privileged
    '{1'b0, 8'h08, 32'h0,         4'hF, 3'd1, 1'b0, 32'h1234_5678},  // R7 R10
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 4'hF, 3'd1, 1'b1, 32'h0},          // R6
    '{1'b0, 8'h0C, 32'h0,         4'hF, 3'd0, 1'b0, 32'hC0DE_0001},  // R6 R10
    '{1'b1, 8'h10, 32'hDEAD_BEEF, 4'hF, 3'd1, 1'b1, 32'h0},          // R5
    '{1'b0, 8'h10, 32'h0,         4'hF, 3'd1, 1'b1, 32'h0},          // R5 R11
    '{1'b0, 8'hFC, 32'h0,         4'hF, 3'd1, 1'b1, 32'h0},          // R5 top offset
    '{1'b1, 8'h00, 32'h0000_EE00, 4'h2, 3'd0, 1'b0, 32'h0},          // R8 lane 1
    '{1'b0, 8'h00, 32'h0,         4'h6, 3'd0, 1'b0, 32'h1122_EE44},  // R8 R9
    '{1'b0, 8'h04, 32'h0,         4'hF, 3'd3, 1'b0, 32'h00BB_00DD}   // R10 unchanged
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves sel/en low at the negedge after completion.
  task automatic xfer(input vec_t v, input string tag);
    int waits = 0;
    sel = 1'b1; en = 1'b0; wr = v.w; addr = v.a; wdata = v.d; strb = v.s; prot = v.p;
    #1 chk(!ready && !err && rdata == 0, {tag, " R4 R11 setup quiet"}, {ready, err, rdata[29:0]}, 0);
    @(negedge clk);
    en = 1'b1;
    #1;
    while (!ready && waits < 40) begin
      chk(!err && rdata == 0, {tag, " R4 R11 wait quiet"}, {err, rdata[30:0]}, 0);
      waits++;
      @(negedge clk);
      #1;
    end
    chk(waits == EXP_WAITS, {tag, " R1 R3 wait count"}, waits, EXP_WAITS);
    chk(err == v.e, {tag, " R4 R5 R6 R7 error"}, err, v.e);
    chk(rdata == v.r, {tag, " R8 R9 R11 read data"}, rdata, v.r);
    @(negedge clk);
    sel = 1'b0; en = 1'b0;
    #1 chk(!ready && !err && rdata == 0, {tag, " R2 single-cycle ready"}, {ready, err, rdata[29:0]}, 0);
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ready && !err && rdata == 0, "R12 outputs in reset", {ready, err, rdata[29:0]}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ready && !err && rdata == 0, "R12 outputs after reset", {ready, err, rdata[29:0]}, 0);

    // R12: words 0..2 reset to zero (privileged read for word 2)
    for (int i = 0; i < 3; i++) begin
      xfer('{1'b0, 8'(4 * i), 32'h0, 4'hF, 3'd1, 1'b0, 32'h0}, "R12 reset word");
    end

    // Table walk: back-to-back transfers (R3 restart on every one)
    for (int i = 0; i < NV; i++) xfer(VEC[i], "vector");

    // R3: idle gap before a transfer gives the same wait count
    repeat (4) @(negedge clk);
    xfer('{1'b0, 8'h0C, 32'h0, 4'h0, 3'd0, 1'b0, 32'hC0DE_0001}, "R3 after idle");

    // R2: select alone without enable never raises ready
    sel = 1'b1; en = 1'b0; addr = 8'h00; wr = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(!ready, "R2 no ready without enable", ready, 0);
    end
    sel = 1'b0;
    @(negedge clk);
    xfer('{1'b0, 8'h00, 32'h0, 4'hF, 3'd0, 1'b0, 32'h1122_EE44}, "R3 after stall");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule